// File: doc/BRIEF.md
# Alarm Time Editor and Match Tone Generator

This block keeps an alarm time as six BCD digits: hours, minutes and seconds, each split into tens and units. While the external mode code selects alarm setting, two single-cycle key pulses edit the alarm. One pulse moves a digit cursor. The other pulse adds one to the digit under the cursor, and each digit wraps at its own limit. The stored alarm is separate from any timekeeping register, and it is also driven out so that a display multiplexer can show it.

The block compares the alarm with the six BCD digits of the running clock on every cycle. When the comparison changes from mismatch to full match, a tone starts. The speaker output then toggles on every pulse of a 100 Hz enable, which gives a square wave. After a fixed number of ticks the tone ends and the speaker stays low. If a new match starts while the tone is playing, the full duration starts again.

Top module: `alarm_unit`

## Requirements
- R1: While `rst` is high and on the edge after it, all alarm digits are 0, the cursor is on seconds-units and `speaker` is low.
- R2: Key pulses have an effect only when `mode_code` equals 3. Under codes 0, 1, 2 and 4, the digits and the cursor stay unchanged.
- R3: Digit i sits in bits [4i+3:4i] of `alarm_digits` and `now_digits`. Index 0 is seconds-units, 1 is seconds-tens, 2 is minutes-units, 3 is minutes-tens, 4 is hours-units and 5 is hours-tens. A `sel_pulse` moves the cursor to the next index, and from 5 it returns to 0.
- R4: An `inc_pulse` adds one to the digit under the cursor. Units digits wrap from 9 to 0, the minutes-tens and seconds-tens digits wrap from 5 to 0, and hours-tens wraps from 2 to 0.
- R5: While hours-tens is 2, hours-units wraps from 3 to 0. When hours-tens steps from 1 to 2 while hours-units is above 3, hours-units is cleared to 0. The alarm hour never goes above 23.
- R6: A pulse takes effect at the next clock edge. When `inc_pulse` and `sel_pulse` come in the same cycle, the increment applies to the digit the cursor was on before it moves.
- R7: A tone starts only on the edge where all six alarm digits first equal all six `now_digits`. A match that already holds when reset is released, a match that continues, and a mismatch in any single digit start no tone.
- R8: While the tone plays, `speaker` inverts on each cycle with `tick_100hz` high. It never changes in a cycle without a tick, and it is low when the tone starts.
- R9: The tick that completes TONE_TICKS ticks after the tone starts drives `speaker` low. It then stays low until the next match.
- R10: A new match while the tone plays reloads the full TONE_TICKS duration. `speaker` keeps its level at the moment of the reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_code | input | MODE_W | Operating mode code; 3 enables alarm editing |
| inc_pulse | input | 1 | Single-cycle pulse that increments the selected digit |
| sel_pulse | input | 1 | Single-cycle pulse that advances the digit cursor |
| tick_100hz | input | 1 | Single-cycle enable at 100 Hz |
| now_digits | input | 24 | Current time, six BCD digits |
| alarm_digits | output | 24 | Stored alarm time, six BCD digits |
| speaker | output | 1 | Tone output |

## Verification
An edit appears on `alarm_digits` one clock after the cycle that carries its pulse. The bench drives each pulse after a falling edge and compares all six digits, against an arithmetic model, one time unit after the next rising edge. The tone counter loads on the rising edge where `now_digits` first equals the alarm, and `speaker` does not move on that edge. Each later tick cycle moves `speaker` on its own rising edge, so the bench samples right after that edge and predicts the level from the number of ticks since the last load. The bench sets TONE_TICKS to 20 so that it can walk through every tick of a full tone and of a reloaded tone.

// File: rtl/alarm_unit_pkg.sv
package alarm_unit_pkg;
  localparam int DIGITS  = 6;
  localparam int BCD_W   = 4;
  localparam int TIME_W  = DIGITS * BCD_W;
  localparam int CUR_W   = 3;

  localparam logic [CUR_W-1:0] POS_SEC_U = 3'd0;
  localparam logic [CUR_W-1:0] POS_SEC_T = 3'd1;
  localparam logic [CUR_W-1:0] POS_MIN_U = 3'd2;
  localparam logic [CUR_W-1:0] POS_MIN_T = 3'd3;
  localparam logic [CUR_W-1:0] POS_HR_U  = 3'd4;
  localparam logic [CUR_W-1:0] POS_HR_T  = 3'd5;

  // Highest legal value of a digit; hours-units depends on hours-tens.
  function automatic logic [BCD_W-1:0] digit_ceiling(input int idx,
                                                     input logic [BCD_W-1:0] hr_tens);
    case (idx)
      1, 3:    digit_ceiling = 4'd5;
      5:       digit_ceiling = 4'd2;
      4:       digit_ceiling = (hr_tens == 4'd2) ? 4'd3 : 4'd9;
      default: digit_ceiling = 4'd9;
    endcase
  endfunction
endpackage

// File: rtl/alarm_digit_editor.sv
module alarm_digit_editor
  import alarm_unit_pkg::*;
#(
  parameter int MODE_W   = 3,
  parameter int SET_CODE = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [MODE_W-1:0]   mode_code,
  input  logic                inc_pulse,
  input  logic                sel_pulse,
  output logic [TIME_W-1:0]   digits_q,
  output logic [CUR_W-1:0]    cursor_q
);
  logic edit_en;
  logic [BCD_W-1:0] hr_tens;

  assign edit_en = (mode_code == MODE_W'(SET_CODE));
  assign hr_tens = digits_q[POS_HR_T*BCD_W +: BCD_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cursor_q <= POS_SEC_U;
    end else if (edit_en && sel_pulse) begin
      cursor_q <= (cursor_q == POS_HR_T) ? POS_SEC_U : cursor_q + 3'd1;
    end
  end

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    logic [BCD_W-1:0] val_q;
    logic [BCD_W-1:0] ceil_v;
    logic             hit;
    logic             clamp;

    assign ceil_v = digit_ceiling(g, hr_tens);
    assign hit    = edit_en && inc_pulse && (cursor_q == CUR_W'(g));

    if (g == 4) begin : g_clamp
      // hours-tens stepping 1 -> 2 would leave an hour above 23
      assign clamp = edit_en && inc_pulse && (cursor_q == POS_HR_T) &&
                     (hr_tens == 4'd1) && (val_q > 4'd3);
    end else begin : g_noclamp
      assign clamp = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        val_q <= '0;
      end else if (hit) begin
        val_q <= (val_q >= ceil_v) ? '0 : val_q + 4'd1;
      end else if (clamp) begin
        val_q <= '0;
      end
    end

    assign digits_q[g*BCD_W +: BCD_W] = val_q;
  end
endmodule

// File: rtl/alarm_match_detect.sv
module alarm_match_detect
  import alarm_unit_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] alarm_time,
  input  logic [TIME_W-1:0] now_time,
  output logic              match_start
);
  logic [DIGITS-1:0] eq;
  logic              all_eq;
  logic              match_q;

  for (genvar g = 0; g < DIGITS; g++) begin : g_cmp
    assign eq[g] = (alarm_time[g*BCD_W +: BCD_W] == now_time[g*BCD_W +: BCD_W]);
  end

  assign all_eq = &eq;

  // Reset to "matched" so a match already present at reset release is silent.
  always_ff @(posedge clk) begin
    if (rst) match_q <= 1'b1;
    else     match_q <= all_eq;
  end

  assign match_start = all_eq && !match_q && !rst;
endmodule

// File: rtl/alarm_tone_gen.sv
module alarm_tone_gen #(
  parameter int TONE_TICKS = 1000,
  parameter int CNT_W      = $clog2(TONE_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             tick,
  output logic             speaker_q,
  output logic [CNT_W-1:0] left_q
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(TONE_TICKS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q    <= '0;
      speaker_q <= 1'b0;
    end else if (start) begin
      left_q    <= LOAD;
    end else if (tick && left_q != '0) begin
      left_q    <= left_q - LAST;
      speaker_q <= (left_q == LAST) ? 1'b0 : ~speaker_q;
    end
  end
endmodule

// File: rtl/alarm_unit.sv
module alarm_unit
  import alarm_unit_pkg::*;
#(
  parameter int MODE_W     = 3,
  parameter int SET_CODE   = 3,
  parameter int TONE_TICKS = 1000,
  localparam int CNT_W     = $clog2(TONE_TICKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_code,
  input  logic              inc_pulse,
  input  logic              sel_pulse,
  input  logic              tick_100hz,
  input  logic [TIME_W-1:0] now_digits,
  output logic [TIME_W-1:0] alarm_digits,
  output logic              speaker
);
  logic [CUR_W-1:0] edit_cursor;
  logic             tone_start;
  logic [CNT_W-1:0] tone_left;

  alarm_digit_editor #(
    .MODE_W   (MODE_W),
    .SET_CODE (SET_CODE)
  ) u_edit (
    .clk       (clk),
    .rst       (rst),
    .mode_code (mode_code),
    .inc_pulse (inc_pulse),
    .sel_pulse (sel_pulse),
    .digits_q  (alarm_digits),
    .cursor_q  (edit_cursor)
  );

  alarm_match_detect u_match (
    .clk         (clk),
    .rst         (rst),
    .alarm_time  (alarm_digits),
    .now_time    (now_digits),
    .match_start (tone_start)
  );

  alarm_tone_gen #(
    .TONE_TICKS (TONE_TICKS),
    .CNT_W      (CNT_W)
  ) u_tone (
    .clk       (clk),
    .rst       (rst),
    .start     (tone_start),
    .tick      (tick_100hz),
    .speaker_q (speaker),
    .left_q    (tone_left)
  );
endmodule

// File: rtl/alarm_unit_chk.sv
module alarm_unit_chk #(
  parameter int MODE_W     = 3,
  parameter int SET_CODE   = 3,
  parameter int TONE_TICKS = 1000,
  parameter int CNT_W      = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [MODE_W-1:0] mode_code,
  input logic              sel_pulse,
  input logic              tick,
  input logic [23:0]       alarm_digits,
  input logic [2:0]        cursor,
  input logic              speaker,
  input logic [CNT_W-1:0]  tone_left,
  input logic              tone_start
);
  // R2
  edit_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_code != MODE_W'(SET_CODE)) |=> $stable(alarm_digits));

  // R3
  cursor_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_code == MODE_W'(SET_CODE) && sel_pulse && cursor == 3'd5) |=> (cursor == 3'd0));

  // R4
  digit_range_chk: assert property (@(posedge clk) disable iff (rst)
    (alarm_digits[3:0] <= 4'd9) && (alarm_digits[7:4] <= 4'd5) &&
    (alarm_digits[11:8] <= 4'd9) && (alarm_digits[15:12] <= 4'd5) &&
    (alarm_digits[19:16] <= 4'd9) && (alarm_digits[23:20] <= 4'd2));

  // R5
  hour_range_chk: assert property (@(posedge clk) disable iff (rst)
    (alarm_digits[23:20] == 4'd2) |-> (alarm_digits[19:16] <= 4'd3));

  // R8
  spk_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(speaker));

  // R9
  silent_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (tone_left == '0) |-> !speaker);

  // R10
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    tone_start |=> (tone_left == CNT_W'(TONE_TICKS)));
endmodule

bind alarm_unit alarm_unit_chk #(
  .MODE_W     (MODE_W),
  .SET_CODE   (SET_CODE),
  .TONE_TICKS (TONE_TICKS),
  .CNT_W      (CNT_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .mode_code    (mode_code),
  .sel_pulse    (sel_pulse),
  .tick         (tick_100hz),
  .alarm_digits (alarm_digits),
  .cursor       (edit_cursor),
  .speaker      (speaker),
  .tone_left    (tone_left),
  .tone_start   (tone_start)
);

// File: tb/sim_alarm_unit.sv
module sim_alarm_unit;
  localparam int CLK_PERIOD = 10;
  localparam int TT         = 20;
  localparam logic [23:0] FAR = 24'hFFFFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  mode_code = 3'd0;
  logic        inc_pulse = 1'b0;
  logic        sel_pulse = 1'b0;
  logic        tick_100hz = 1'b0;
  logic [23:0] now_digits = FAR;
  logic [23:0] alarm_digits;
  logic        speaker;

  int checks = 0;
  int fails  = 0;
  int m[6];
  int cur = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_unit #(.MODE_W(3), .SET_CODE(3), .TONE_TICKS(TT)) u0 (
    .clk(clk), .rst(rst), .mode_code(mode_code), .inc_pulse(inc_pulse),
    .sel_pulse(sel_pulse), .tick_100hz(tick_100hz), .now_digits(now_digits),
    .alarm_digits(alarm_digits), .speaker(speaker)
  );

  function automatic logic [23:0] packm();
    logic [23:0] v;
    for (int i = 0; i < 6; i++) v[i*4 +: 4] = 4'(m[i]);
    return v;
  endfunction

  function automatic int ceil_of(int i);
    if (i == 1 || i == 3) return 5;
    if (i == 5) return 2;
    if (i == 4 && m[5] == 2) return 3;
    return 9;
  endfunction

  task automatic chk_vec(input logic [23:0] act, input logic [23:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: alarm_digits=%h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_bit(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: speaker=%b expected %b", req, act, exp);
    end
  endtask

  task automatic edit_step(input logic [2:0] md, input logic inc, input logic sel, input string req);
    @(negedge clk);
    mode_code = md; inc_pulse = inc; sel_pulse = sel;
    @(posedge clk); #1;
    inc_pulse = 1'b0; sel_pulse = 1'b0;
    if (md == 3'd3) begin
      if (inc) begin
        if (m[cur] >= ceil_of(cur)) m[cur] = 0;
        else begin
          if (cur == 5 && m[5] == 1 && m[4] > 3) m[4] = 0;
          m[cur] = m[cur] + 1;
        end
      end
      if (sel) cur = (cur == 5) ? 0 : cur + 1;
    end
    chk_vec(alarm_digits, packm(), req);
  endtask

  task automatic set_now(input logic [23:0] v);
    @(negedge clk); now_digits = v;
    @(posedge clk); #1;
  endtask

  task automatic tick_step(input logic tk);
    @(negedge clk); tick_100hz = tk;
    @(posedge clk); #1;
    tick_100hz = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    for (int i = 0; i < 6; i++) m[i] = 0;
    cur = 0;
    chk_vec(alarm_digits, 24'h0, "R1");
    chk_bit(speaker, 1'b0, "R1");
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [23:0] a;
    for (int i = 0; i < 6; i++) m[i] = 0;
    do_reset();
    edit_step(3'd3, 1'b0, 1'b0, "R1");

    // R4/R3: every digit stepped past its wrap point, cursor walked round
    for (int p = 0; p < 6; p++) begin
      for (int n = 0; n < 12; n++) edit_step(3'd3, 1'b1, 1'b0, "R4");
      edit_step(3'd3, 1'b0, 1'b1, "R3");
    end
    edit_step(3'd3, 1'b1, 1'b0, "R3");

    // R2: other mode codes ignore both pulses
    for (int md = 0; md < 5; md++) begin
      if (md != 3) edit_step(3'(md), 1'b1, 1'b1, "R2");
    end
    edit_step(3'd3, 1'b1, 1'b0, "R2");

    // R5: hours-tens 1 -> 2 with hours-units above 3, then units wrap at 3
    while (cur != 5) edit_step(3'd3, 1'b0, 1'b1, "R3");
    while (m[5] != 1) edit_step(3'd3, 1'b1, 1'b0, "R4");
    while (cur != 4) edit_step(3'd3, 1'b0, 1'b1, "R3");
    while (m[4] != 7) edit_step(3'd3, 1'b1, 1'b0, "R4");
    edit_step(3'd3, 1'b0, 1'b1, "R3");
    edit_step(3'd3, 1'b1, 1'b0, "R5");
    chk_vec({4'(m[5]), 4'(m[4])}, 8'h20, "R5");
    while (cur != 4) edit_step(3'd3, 1'b0, 1'b1, "R3");
    for (int n = 0; n < 5; n++) edit_step(3'd3, 1'b1, 1'b0, "R5");

    // R6 and R2: mixed sweep of modes and coincident pulses
    for (int i = 0; i < 300; i++) begin
      edit_step((i % 4 == 0) ? 3'((i / 4) % 5) : 3'd3,
                (i % 3 != 0), (i % 7 == 0) || (i % 11 == 0), "R6");
    end

    // R7: a mismatch in any one digit starts no tone
    a = packm();
    mode_code = 3'd0;
    for (int d = 0; d < 6; d++) begin
      logic [23:0] v;
      v = a;
      v[d*4 +: 4] = 4'hF;
      set_now(v);
      for (int k = 0; k < 3; k++) begin
        tick_step(1'b1);
        chk_bit(speaker, 1'b0, "R7");
      end
    end

    // R7/R8/R9: full match, one complete tone
    set_now(a);
    chk_bit(speaker, 1'b0, "R8");
    for (int k = 1; k <= TT + 3; k++) begin
      tick_step(1'b1);
      chk_bit(speaker, (k < TT) ? 1'(k % 2) : 1'b0, (k < TT) ? "R8" : "R9");
      if (k == 3) begin
        tick_step(1'b0);
        chk_bit(speaker, 1'b1, "R8");
      end
    end

    // R10: a new match part-way reloads the duration
    set_now(FAR);
    set_now(a);
    for (int k = 1; k <= 5; k++) tick_step(1'b1);
    chk_bit(speaker, 1'b1, "R10");
    set_now(FAR);
    set_now(a);
    chk_bit(speaker, 1'b1, "R10");
    for (int k = 1; k <= TT + 2; k++) begin
      tick_step(1'b1);
      chk_bit(speaker, (k < TT) ? 1'(1 ^ (k % 2)) : 1'b0, (k < TT) ? "R10" : "R9");
    end

    // R7: a match held across reset release does not sound
    now_digits = 24'h0;
    do_reset();
    for (int k = 0; k < 6; k++) begin
      tick_step(1'b1);
      chk_bit(speaker, 1'b0, "R7");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule